// File: doc/BRIEF.md
# Dual-Output PWM Time Base

This block makes two pulse-width-modulated outputs from a single 16-bit time-base counter that counts up. The counter advances once per time-base tick. A tick comes from the system clock after two prescalers in series: a coarse one that divides by a power of two and a fine one that divides by an even step. Each output follows its own action rules. It goes high when the counter passes zero and toggles when the counter equals that output's compare value. The duty cycle therefore follows from the compare value and the frequency from the period and the two prescaler codes.

Software programs the block through a one-cycle write port. The port loads the control word, the period, the two compare values and the counter itself. The control word holds the two prescaler codes and a run bit. With the run bit clear, the counter is frozen and both outputs are held low.

Top module: `dpwm_top`

## Requirements
- R1: The coarse prescaler code c (control bits [2:0]) divides the clock by 2^c, so a code of 3 with the fine code at 0 gives one tick every 8 clock cycles.
- R2: The fine prescaler code f (control bits [5:3]) divides by 1 when f is 0 and by 2*f otherwise, so f=1 gives a tick every 2 cycles and f=7 every 14 cycles.
- R3: Tick spacing is the product of the two dividers. Coarse 2 with fine 3 gives 24 cycles, and the counter and outputs change only on a tick or a write.
- R4: While running, each effective tick raises the counter by one until it reaches the period, and the next tick returns it to 0. The counter is visible on `time_cnt`.
- R5: A period write (address 1) takes effect on the next tick. If the counter is already at or above the new period, that tick returns it to 0.
- R6: While running, on each tick an output goes high when the counter is 0 and toggles when the counter equals its compare value. A uses address 2 and B uses address 3, so a period of 9 with compares 3 and 6 gives 3 and 6 high cycles out of 10.
- R7: When the counter is 0 and also equals the compare value on the same tick, the toggle wins over the set, so a compare of 0 gives a square wave with a period of two counter cycles.
- R8: A compare value above the period never matches, so that output stays high for the whole cycle.
- R9: With the run bit (control bit 6) clear, no ticks occur, the counter holds its value and both outputs are low.
- R10: Any control write (address 0) clears the counter. A counter write (address 4) loads `wr_data`, and a write on either address cancels a tick that falls in the same cycle.
- R11: Any control write restarts the prescaler, so the first tick after the write arrives a full new division interval later.
- R12: Reset drives both outputs low, clears the counter and all registers, and selects the stopped mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | 0 control, 1 period, 2 compare A, 3 compare B, 4 counter |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| time_cnt | output | 16 | Current time-base counter value |

## Verification
The hardest case to reach from the ports is a control write that lands partway through a long division interval. Only the timing of the first tick that follows shows whether the prescaler restarted. The stimulus runs with a 24-cycle divider, waits 10 cycles and rewrites the same control word, then counts the cycles until the counter first moves. The bench also rewrites the period while the counter sits above the new value, and sets a compare of zero so that the zero event and the match land on the same tick. A cycle-accurate reference model checks every cycle of each of these cases.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_PERIOD = 3'd1,
        ADR_CMP_A  = 3'd2,
        ADR_CMP_B  = 3'd3,
        ADR_COUNT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              run;
        logic [CODE_W-1:0] fine;
        logic [CODE_W-1:0] coarse;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dpwm_prescale.sv
module dpwm_prescale
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] coarse,
    input  logic [CODE_W-1:0] fine,
    output logic              tick
);
    localparam int FINE_MAX = (1 << CODE_W) - 1;
    localparam int DIV_W    = FINE_MAX + CODE_W + 2;

    logic [DIV_W-1:0] coarse_div, fine_div, div_m1;
    logic [DIV_W-1:0] psc_d, psc_q;

    always_comb begin
        coarse_div = DIV_W'(1) << coarse;
        fine_div   = (fine == '0) ? DIV_W'(1) : DIV_W'({fine, 1'b0});
        div_m1     = (coarse_div * fine_div) - DIV_W'(1);
        tick       = run && (psc_q == div_m1);
        if (restart || !run || tick) begin
            psc_d = '0;
        end else begin
            psc_d = psc_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            cnt_d = (cnt_q >= period) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dpwm_action.sv
module dpwm_action #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             force_low,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    output logic             out
);
    logic out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (force_low) begin
            out_d = 1'b0;
        end else if (evt) begin
            if (count == cmp)       out_d = ~out_q;
            else if (count == '0)   out_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign out = out_q;
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [CNT_W-1:0] time_cnt
);
    localparam int NCH = 2;

    typedef struct packed {
        ctrl_t                     ctrl;
        logic [CNT_W-1:0]          prd;
        logic [NCH-1:0][CNT_W-1:0] cmp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctrl_wr, cnt_wr, tick, step, force_low, run_q;
    logic [NCH-1:0] pwm;

    always_comb begin
        cfg_d     = cfg_q;
        ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
        cnt_wr    = wr_en && (wr_addr == ADR_COUNT);
        force_low = ctrl_wr && !wr_data[CTRL_W-1];
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL:   cfg_d.ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
                ADR_PERIOD: cfg_d.prd    = CNT_W'(wr_data);
                ADR_CMP_A:  cfg_d.cmp[0] = CNT_W'(wr_data);
                ADR_CMP_B:  cfg_d.cmp[1] = CNT_W'(wr_data);
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign run_q = cfg_q.ctrl.run;
    assign step  = tick && !ctrl_wr && !cnt_wr;

    dpwm_prescale u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (ctrl_wr),
        .coarse  (cfg_q.ctrl.coarse),
        .fine    (cfg_q.ctrl.fine),
        .tick    (tick)
    );

    dpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctrl_wr),
        .load     (cnt_wr),
        .load_val (CNT_W'(wr_data)),
        .step     (step),
        .period   (cfg_q.prd),
        .count    (time_cnt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dpwm_action #(.CNT_W(CNT_W)) u_act (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (step),
            .force_low (force_low),
            .count     (time_cnt),
            .cmp       (cfg_q.cmp[ch]),
            .out       (pwm[ch])
        );
    end

    assign pwm_a = pwm[0];
    assign pwm_b = pwm[1];
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [15:0]      wr_data,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic [CNT_W-1:0] time_cnt,
    input logic             run,
    input logic             tick
);
    logic side_wr;
    assign side_wr = wr_en && (wr_addr == 3'd0 || wr_addr == 3'd4);

    a_r9_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm_a && !pwm_b));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(time_cnt));

    a_r9_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    a_r10_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (time_cnt == '0));

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4) |=> (time_cnt == CNT_W'($past(wr_data))));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !side_wr) |=>
        (time_cnt == CNT_W'($past(time_cnt) + CNT_W'(1)) || time_cnt == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !side_wr) |=>
        ($stable(time_cnt) && $stable(pwm_a) && $stable(pwm_b)));
endmodule

bind dpwm_top dpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .time_cnt (time_cnt),
    .run      (run_q),
    .tick     (tick)
);

// File: tb/tb_dpwm_top.sv
`timescale 1ns/1ps
module tb_dpwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;
    logic [15:0] time_cnt;

    always #2.5 clk = ~clk;

    dpwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .time_cnt(time_cnt)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R12";
    bit    done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reference model built from the requirements
    logic        m_run, m_a, m_b;
    logic [2:0]  m_coarse, m_fine;
    logic [15:0] m_prd, m_ca, m_cb, m_cnt;
    int          m_psc;
    logic [31:0] exp_q[$];

    function automatic int ref_div(input logic [2:0] c, input logic [2:0] f);
        return (1 << c) * ((f == 0) ? 1 : 2 * int'(f));
    endfunction

    function automatic logic act_out(input logic o, input logic [15:0] cnt,
                                     input logic [15:0] cmp);
        if (cnt == cmp) return ~o;
        if (cnt == 0)   return 1'b1;
        return o;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_a = 0; m_b = 0; m_coarse = 0; m_fine = 0;
            m_prd = 0; m_ca = 0; m_cb = 0; m_cnt = 0; m_psc = 0;
        end else begin
            logic wc, wn, tk, ev, na, nb;
            logic [15:0] nc;
            int np;
            wc = wr_en && wr_addr == 3'd0;
            wn = wr_en && wr_addr == 3'd4;
            tk = m_run && (m_psc == ref_div(m_coarse, m_fine) - 1);
            ev = tk && !wc && !wn;
            na = m_a; nb = m_b; nc = m_cnt;
            if (wc && !wr_data[6]) begin
                na = 0; nb = 0;
            end else if (ev) begin
                na = act_out(m_a, m_cnt, m_ca);
                nb = act_out(m_b, m_cnt, m_cb);
            end
            if (wc)      nc = 0;
            else if (wn) nc = wr_data;
            else if (ev) nc = (m_cnt >= m_prd) ? 16'd0 : m_cnt + 16'd1;
            np = (wc || !m_run || tk) ? 0 : m_psc + 1;
            if (wc) begin
                m_run = wr_data[6]; m_fine = wr_data[5:3]; m_coarse = wr_data[2:0];
            end
            if (wr_en && wr_addr == 3'd1) m_prd = wr_data;
            if (wr_en && wr_addr == 3'd2) m_ca = wr_data;
            if (wr_en && wr_addr == 3'd3) m_cb = wr_data;
            m_a = na; m_b = nb; m_cnt = nc; m_psc = np;
            exp_q.push_back({14'd0, na, nb, nc});
        end
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(phase, "scoreboard {a,b,count}", {14'd0, pwm_a, pwm_b, time_cnt}, e);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n, output int ha, output int hb, output int mx);
        ha = 0; hb = 0; mx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(pwm_a); hb += int'(pwm_b);
            if (int'(time_cnt) > mx) mx = int'(time_cnt);
        end
    endtask

    task automatic first_step(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (time_cnt == 16'd0 && n < 5000);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        int ha, hb, mx, n;
        repeat (4) @(negedge clk);
        chk("R12", "pwm_a in reset", pwm_a, 0);
        chk("R12", "count in reset", time_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "pwm_b after reset", pwm_b, 0);

        phase = "R6";
        wr(3'd1, 16'd9); wr(3'd2, 16'd3); wr(3'd3, 16'd6);
        wr(3'd0, 16'h0040);
        repeat (12) @(negedge clk);
        measure(10, ha, hb, mx);
        chk("R6", "A high cycles per period", ha, 3);
        chk("R6", "B high cycles per period", hb, 6);
        chk("R4", "counter peak equals period", mx, 9);

        phase = "R7";
        wr(3'd2, 16'd0);
        repeat (20) @(negedge clk);
        measure(20, ha, hb, mx);
        chk("R7", "A high cycles over two periods", ha, 10);

        phase = "R8";
        wr(3'd3, 16'd20);
        repeat (12) @(negedge clk);
        measure(10, ha, hb, mx);
        chk("R8", "B high whole period", hb, 10);

        phase = "R5";
        repeat (7) @(negedge clk);
        wr(3'd1, 16'd4);
        repeat (12) @(negedge clk);
        measure(10, ha, hb, mx);
        chk("R5", "counter peak after period write", mx, 4);

        phase = "R1";
        wr(3'd0, 16'h0043);
        first_step(n);
        chk("R1", "cycles to first tick coarse 3", n, 8);
        phase = "R2";
        wr(3'd0, 16'h0048);
        first_step(n);
        chk("R2", "cycles to first tick fine 1", n, 2);
        wr(3'd0, 16'h0078);
        first_step(n);
        chk("R2", "cycles to first tick fine 7", n, 14);
        phase = "R3";
        wr(3'd0, 16'h005A);
        first_step(n);
        chk("R3", "cycles to first tick coarse 2 fine 3", n, 24);
        repeat (40) @(negedge clk);

        phase = "R11";
        repeat (10) @(negedge clk);
        wr(3'd0, 16'h005A);
        first_step(n);
        chk("R11", "restart gives full interval", n, 24);

        phase = "R10";
        wr(3'd4, 16'd3);
        chk("R10", "direct counter load", time_cnt, 3);
        repeat (30) @(negedge clk);

        phase = "R9";
        wr(3'd0, 16'h0002);
        chk("R9", "A low when stopped", pwm_a, 0);
        chk("R10", "counter cleared on disable", time_cnt, 0);
        wr(3'd4, 16'd7);
        repeat (50) @(negedge clk);
        chk("R9", "counter frozen when stopped", time_cnt, 7);
        chk("R9", "B low when stopped", pwm_b, 0);

        phase = "R10";
        wr(3'd0, 16'h0040);
        chk("R10", "counter cleared on enable", time_cnt, 0);
        repeat (60) @(negedge clk);

        done = 1'b1;
        report();
        $finish;
    end
endmodule